// File: doc/BRIEF.md
# FEC Rate Ratio Clock Divider

This block derives the fractional clock relationships needed when forward error correction inflates a data stream. A 3-bit code selects a divide value for the synthesizer feedback path and, for half of the codes, a second divide value for the recovered-clock path. The two values always differ by one, so that the two clocks sit at 14/15, 15/14, 16/17 or 17/16 of each other. Each divider emits a one-cycle strobe when its count ends.

Alongside the dividers, an accumulator produces a gapped enable. It passes N of every N+1 input cycles, where N is 14 or 16. Upstream logic can use it to pace a slower stream on the faster clock. Codes that leave the recovered-clock divider idle correspond to correction strengths the internal dividers cannot reach. For those codes an output flags that an external bypass clock must be supplied.

A selection change never shortens or stretches a period that is already running. Each divider, and the gapped enable, picks up a new code only at the start of its next period.

Top module: `fec_ratio_divider`

## Requirements
- R1: With code bits {b2,b1,b0} (b0 = fec_sel[0], b1 = fec_sel[1], b2 = fec_sel[2]), the synthesizer divide is 17, 16, 15 or 14 for {b1,b0} = 00, 01, 10, 11. `vco_tc` pulses once every that many cycles.
- R2: When b2 = 1, the recovered-clock divide is 16, 17, 14 or 15 for {b1,b0} = 00, 01, 10, 11. `rc_tc` pulses once every that many cycles.
- R3: When b2 = 0, `bypass_req` is high, and `rc_tc` never pulses while such a code is held from a period start. When b2 = 1, `bypass_req` is low.
- R4: Each strobe is high for exactly one cycle. Out of reset, the first `vco_tc` follows the D-th clock edge after reset is released, where D is the divide.
- R5: A change of `fec_sel` in mid-period leaves the running divider period at its old length. The new divide applies from the following period.
- R6: `gap_en` is high on exactly N of every N+1 cycles, with N = 14 when b1 = 1 and N = 16 when b1 = 0. The single low cycle is the first cycle of each period; after reset it follows the first edge.
- R7: A synchronous, active-high `rst` holds all strobes and `gap_en` low and restarts every count from the beginning of a period.
- R8: A change of the N value takes effect for `gap_en` only at the start of the next N+1 period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| fec_sel | input | 3 | FEC code select {b2,b1,b0} |
| vco_tc | output | 1 | Terminal-count strobe of the synthesizer-path divider |
| rc_tc | output | 1 | Terminal-count strobe of the recovered-clock divider |
| gap_en | output | 1 | Gapped enable, N of every N+1 cycles |
| bypass_req | output | 1 | High when the code needs an external bypass clock |

## Verification
The assertions take `fec_sel` to be a known value at every clock edge after reset. They also take `rst` to be held for at least one edge before activity begins, so the spacing and single-gap checks start from a clean period. The stimulus changes `fec_sel` and `rst` only one time unit after a rising edge, never near a sampling edge. It always asserts reset before the first scenario. Mid-period code changes are included on purpose, so that the assertions see the latched-period behaviour rather than only steady codes.

// File: rtl/fecdiv_pkg.sv
package fecdiv_pkg;

  localparam int CNT_W    = 5;
  localparam int SEL_W    = 3;
  localparam int LO_BASE  = 14;
  localparam int HI_BASE  = 16;

  typedef struct packed {
    logic [CNT_W-1:0] vco_div;
    logic [CNT_W-1:0] rc_div;
    logic             rc_used;
    logic [CNT_W-1:0] gap_num;
    logic [CNT_W-1:0] gap_den;
  } fec_plan_t;

  // b1 chooses the 14/15 or 16/17 family; b0 chooses which side is larger
  function automatic fec_plan_t decode_fec(input logic [SEL_W-1:0] sel);
    fec_plan_t        p;
    logic [CNT_W-1:0] base;
    base      = sel[1] ? CNT_W'(LO_BASE) : CNT_W'(HI_BASE);
    p.vco_div = sel[0] ? base : base + CNT_W'(1);
    p.rc_div  = sel[0] ? base + CNT_W'(1) : base;
    p.rc_used = sel[2];
    p.gap_num = base;
    p.gap_den = base + CNT_W'(1);
    return p;
  endfunction

endpackage

// File: rtl/fecdiv_period.sv
module fecdiv_period #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_req,
  input  logic [W-1:0] div_req,
  output logic         tc,
  output logic         start
);

  logic [W-1:0] cnt;
  logic [W-1:0] div_q;
  logic         run_q;
  logic         at_top;
  logic         run_eff;
  logic [W-1:0] div_eff;
  logic         last;

  // a new divide value is only taken when a period begins
  assign at_top  = (cnt == '0);
  assign run_eff = at_top ? run_req : run_q;
  assign div_eff = at_top ? div_req : div_q;
  assign last    = run_eff && (cnt == div_eff - W'(1));
  assign start   = at_top && run_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      div_q <= '0;
      run_q <= 1'b0;
      tc    <= 1'b0;
    end else begin
      run_q <= run_eff;
      div_q <= div_eff;
      tc    <= last;
      cnt   <= (!run_eff || last) ? '0 : cnt + W'(1);
    end
  end

endmodule

// File: rtl/fecdiv_gapper.sv
module fecdiv_gapper #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] num_req,
  input  logic [W-1:0] den_req,
  output logic         en
);

  logic [W-1:0] acc;
  logic [W-1:0] num_q;
  logic [W-1:0] den_q;
  logic         at_top;
  logic [W-1:0] num_eff;
  logic [W-1:0] den_eff;
  logic [W:0]   sum;
  logic         pass;
  logic [W-1:0] acc_n;

  // the ratio is re-sampled only when the accumulator is back at zero
  assign at_top  = (acc == '0);
  assign num_eff = at_top ? num_req : num_q;
  assign den_eff = at_top ? den_req : den_q;
  assign sum     = {1'b0, acc} + {1'b0, num_eff};
  assign pass    = (sum >= {1'b0, den_eff});
  assign acc_n   = pass ? W'(sum - {1'b0, den_eff}) : W'(sum);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      num_q <= '0;
      den_q <= '0;
      en    <= 1'b0;
    end else begin
      acc   <= acc_n;
      num_q <= num_eff;
      den_q <= den_eff;
      en    <= pass;
    end
  end

endmodule

// File: rtl/fec_ratio_divider.sv
module fec_ratio_divider
  import fecdiv_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] fec_sel,
  output logic             vco_tc,
  output logic             rc_tc,
  output logic             gap_en,
  output logic             bypass_req
);

  localparam int NDIV = 2;

  fec_plan_t         plan;
  logic [NDIV-1:0]   run_req;
  logic [CW-1:0]     div_req [NDIV];
  logic [NDIV-1:0]   tc_w;
  logic [NDIV-1:0]   start_w;
  logic              vco_start;
  logic              rc_start;

  assign plan       = decode_fec(fec_sel);
  assign run_req[0] = 1'b1;
  assign div_req[0] = CW'(plan.vco_div);
  assign run_req[1] = plan.rc_used;
  assign div_req[1] = CW'(plan.rc_div);

  generate
    for (genvar i = 0; i < NDIV; i++) begin : g_div
      fecdiv_period #(.W(CW)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run_req (run_req[i]),
        .div_req (div_req[i]),
        .tc      (tc_w[i]),
        .start   (start_w[i])
      );
    end
  endgenerate

  fecdiv_gapper #(.W(CW)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .num_req (CW'(plan.gap_num)),
    .den_req (CW'(plan.gap_den)),
    .en      (gap_en)
  );

  assign vco_tc     = tc_w[0];
  assign rc_tc      = tc_w[1];
  assign vco_start  = start_w[0];
  assign rc_start   = start_w[1];
  assign bypass_req = !plan.rc_used;

endmodule

// File: rtl/fecdiv_checker.sv
module fecdiv_checker (
  input logic clk,
  input logic rst,
  input logic vco_tc,
  input logic rc_tc,
  input logic gap_en,
  input logic bypass_req,
  input logic vco_start,
  input logic rc_start
);

  logic [5:0] vco_since;
  logic       vco_seen;
  logic       live;

  always_ff @(posedge clk) begin
    if (rst) begin
      vco_since <= '0;
      vco_seen  <= 1'b0;
      live      <= 1'b0;
    end else begin
      live <= 1'b1;
      if (vco_tc) begin
        vco_since <= '0;
        vco_seen  <= 1'b1;
      end else if (vco_since != 6'h3f) begin
        vco_since <= vco_since + 6'd1;
      end
    end
  end

  AST_VCO_SPACING: assert property (@(posedge clk) disable iff (rst)
    (vco_tc && vco_seen) |-> (vco_since >= 6'd13 && vco_since <= 6'd16)); // R1

  AST_BYPASS_NO_START: assert property (@(posedge clk) disable iff (rst)
    bypass_req |-> !rc_start); // R3

  AST_VCO_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    vco_tc |=> !vco_tc); // R4

  AST_RC_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    rc_tc |=> !rc_tc); // R4

  AST_VCO_RESTART: assert property (@(posedge clk) disable iff (rst)
    vco_tc |-> vco_start); // R5

  AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (live && !gap_en) |=> gap_en); // R6

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    !live |-> (!vco_tc && !rc_tc && !gap_en)); // R7

endmodule

bind fec_ratio_divider fecdiv_checker u_fecdiv_checker (
  .clk        (clk),
  .rst        (rst),
  .vco_tc     (vco_tc),
  .rc_tc      (rc_tc),
  .gap_en     (gap_en),
  .bypass_req (bypass_req),
  .vco_start  (vco_start),
  .rc_start   (rc_start)
);

// File: tb/fec_ratio_divider_bench.sv
`timescale 1ns/1ps
module fec_ratio_divider_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] fec_sel = 3'd0;
  logic       vco_tc, rc_tc, gap_en, bypass_req;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state: position within each period
  int v_pos = 0, v_per = 0;
  int r_pos = 0, r_per = 0;
  bit r_on  = 0;
  int g_pos = 0, g_per = 0;
  bit e_vtc = 0, e_rtc = 0, e_gap = 0;
  int n_edge = 0;

  always #2 clk = ~clk;

  fec_ratio_divider u_fec_ratio_divider (
    .clk(clk), .rst(rst), .fec_sel(fec_sel),
    .vco_tc(vco_tc), .rc_tc(rc_tc), .gap_en(gap_en), .bypass_req(bypass_req)
  );

  function automatic int tbl_vco(input logic [2:0] c);
    case (c)
      3'd0, 3'd4: return 17;
      3'd1, 3'd5: return 16;
      3'd2, 3'd6: return 15;
      default:    return 14;
    endcase
  endfunction

  function automatic int tbl_rc(input logic [2:0] c);
    case (c)
      3'd4:    return 16;
      3'd5:    return 17;
      3'd6:    return 14;
      3'd7:    return 15;
      default: return 0;
    endcase
  endfunction

  function automatic int tbl_gap_period(input logic [2:0] c);
    return (c == 3'd2 || c == 3'd3 || c == 3'd6 || c == 3'd7) ? 15 : 17;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    n_edge++;
    if (rst) begin
      v_pos = 0; r_pos = 0; g_pos = 0; r_on = 0;
      e_vtc = 0; e_rtc = 0; e_gap = 0;
    end else begin
      if (v_pos == 0) v_per = tbl_vco(fec_sel);
      e_vtc = (v_pos == v_per - 1);
      v_pos = e_vtc ? 0 : v_pos + 1;
      if (r_pos == 0) begin
        r_on  = fec_sel[2];
        r_per = tbl_rc(fec_sel);
      end
      if (r_on) begin
        e_rtc = (r_pos == r_per - 1);
        r_pos = e_rtc ? 0 : r_pos + 1;
      end else begin
        e_rtc = 0;
        r_pos = 0;
      end
      if (g_pos == 0) g_per = tbl_gap_period(fec_sel);
      e_gap = (g_pos != 0);
      g_pos = (g_pos + 1 == g_per) ? 0 : g_pos + 1;
    end
    #1;
    check(tag, "vco_tc", int'(vco_tc), int'(e_vtc));
    check(tag, "rc_tc", int'(rc_tc), int'(e_rtc));
    check(tag, "gap_en", int'(gap_en), int'(e_gap));
    check("R3", "bypass_req", int'(bypass_req), int'(!fec_sel[2]));
  endtask

  task automatic do_reset(input logic [2:0] code);
    rst = 1'b1;
    fec_sel = code;
    step("R7");
    step("R7");
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(3'd7);
    check("R7", "vco_tc in reset", int'(vco_tc), 0);
    check("R7", "rc_tc in reset", int'(rc_tc), 0);
    check("R7", "gap_en in reset", int'(gap_en), 0);
    step("R7");
    check("R7", "gap low after first edge", int'(gap_en), 0);
  endtask

  task automatic t_vco_codes();
    for (int c = 0; c < 8; c++) begin
      int last = -1;
      int first = -1;
      do_reset(3'(c));
      for (int k = 0; k < 2 * tbl_vco(3'(c)) + 3; k++) begin
        step("R1");
        if (vco_tc) begin
          if (first < 0) first = k + 1;
          if (last >= 0) check("R1", "vco period", k - last, tbl_vco(3'(c)));
          last = k;
        end
      end
      check("R4", "first vco strobe edge", first, tbl_vco(3'(c)));
    end
  endtask

  task automatic t_rc_codes();
    for (int c = 4; c < 8; c++) begin
      int last = -1;
      do_reset(3'(c));
      for (int k = 0; k < 2 * tbl_rc(3'(c)) + 3; k++) begin
        step("R2");
        if (rc_tc) begin
          if (last >= 0) check("R2", "rc period", k - last, tbl_rc(3'(c)));
          last = k;
        end
      end
    end
  endtask

  task automatic t_bypass();
    for (int c = 0; c < 4; c++) begin
      int hits = 0;
      do_reset(3'(c));
      for (int k = 0; k < 40; k++) begin
        step("R3");
        if (rc_tc) hits++;
      end
      check("R3", "rc strobes while bypassed", hits, 0);
      check("R3", "bypass flag", int'(bypass_req), 1);
    end
  endtask

  task automatic t_mid_change();
    int first = -1;
    do_reset(3'd4);
    for (int k = 0; k < 5; k++) step("R5");
    fec_sel = 3'd7;
    for (int k = 5; k < 60; k++) begin
      step("R5");
      if (vco_tc && first < 0) first = k + 1;
    end
    check("R5", "old period kept after change", first, 17);
  endtask

  task automatic t_gap_ratio();
    int ones = 0;
    do_reset(3'd6);
    for (int k = 0; k < 45; k++) begin
      step("R6");
      ones += int'(gap_en);
    end
    check("R6", "enables in 3x15 cycles", ones, 42);
    ones = 0;
    do_reset(3'd1);
    for (int k = 0; k < 51; k++) begin
      step("R6");
      ones += int'(gap_en);
    end
    check("R6", "enables in 3x17 cycles", ones, 48);
  endtask

  task automatic t_gap_change();
    do_reset(3'd0);
    for (int k = 0; k < 7; k++) step("R8");
    fec_sel = 3'd2;
    for (int k = 0; k < 10; k++) step("R8");
    check("R8", "old gap period still running", int'(gap_en), 1);
    for (int k = 0; k < 50; k++) step("R8");
  endtask

  task automatic t_reset_mid();
    do_reset(3'd5);
    for (int k = 0; k < 9; k++) step("R7");
    rst = 1'b1;
    step("R7");
    check("R7", "strobes cleared", int'(vco_tc | rc_tc | gap_en), 0);
    rst = 1'b0;
    for (int k = 0; k < 40; k++) step("R7");
  endtask

  initial begin
    t_reset_state();
    t_vco_codes();
    t_rc_codes();
    t_bypass();
    t_mid_change();
    t_gap_ratio();
    t_gap_change();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule